// File: doc/BRIEF.md
# Resistive Touch Sample Frame Evaluator

This block takes the conversion results that a four-wire resistive panel converter produces, always in groups of twelve 10-bit values, and reduces each group to a pen state and a pair of averaged coordinates. A frame is opened by a one-cycle `frame_start` pulse. The next twelve samples accepted on the valid/ready input fill slots 1 to 12. Samples that arrive while no frame is open are dropped.

Slots 2 and 12 are the contact guards: the pen counts as down only when both are strictly below a programmable threshold. Slots 1 and 11 are settling reads and are thrown away. Slots 3 to 6 carry X and slots 7 to 10 carry Y. Each coordinate is the mean of its four readings, with the fraction dropped.

The threshold register has its own readback pin. An indexed readback port shows the raw samples of the last complete frame. The input stream never applies back-pressure: `smp_ready` is held high, so a sample transfers on every cycle in which `smp_valid` is high. The upstream converter may leave any number of idle cycles between samples.

Top module: `touch_frame_eval`

## Requirements
- R1: After `frame_start`, the next 12 cycles with `smp_valid` high fill slots 1..12 in order. `frame_done` is high for exactly one cycle, the cycle after slot 12 transfers. `smp_ready` is always 1. Samples sent while no frame is open are ignored.
- R2: On a pen-down frame, `x_coord` = (slot3+slot4+slot5+slot6)>>2 and `y_coord` = (slot7+slot8+slot9+slot10)>>2.
- R3: `pen_down` becomes 1 when slot 2 < threshold and slot 12 < threshold. Otherwise it becomes 0. A guard equal to the threshold counts as not below.
- R4: The values in slots 1 and 11 have no effect on the pen state or the coordinates.
- R5: On a frame where the pen is up, `x_coord` and `y_coord` keep their previous values.
- R6: `pen_down_evt` and `pen_up_evt` each pulse for one cycle together with `frame_done`, and only when `pen_down` changes from its value at the previous frame.
- R7: After reset the threshold is 750, `pen_down` is 0 and the coordinates are 0. `thr_value` always shows the threshold in force.
- R8: A threshold write of a value above 1023 is ignored and the old value is kept. Writes of 0..1023 take effect from the next cycle.
- R9: `raw_data` shows slot `raw_idx`+1 of the most recent complete frame, for `raw_idx` 0..11. It reads 0 for a larger index. An incomplete frame leaves it unchanged.
- R10: A `frame_start` in the middle of a frame discards the partial frame, and the next accepted sample is slot 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Opens a new frame, abandoning any open one |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_ready | output | 1 | Always 1; the block accepts every offered sample |
| smp_data | input | 10 | Conversion result |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | 16 | Requested threshold (values above 1023 are ignored) |
| thr_value | output | 10 | Threshold currently in force |
| raw_idx | input | 4 | Readback slot index, 0 based |
| raw_data | output | 10 | Raw sample of the last complete frame |
| pen_down | output | 1 | Pen state from the last frame |
| pen_down_evt | output | 1 | One-cycle pulse when the pen becomes down |
| pen_up_evt | output | 1 | One-cycle pulse when the pen becomes up |
| x_coord | output | 10 | Averaged X of the last pen-down frame |
| y_coord | output | 10 | Averaged Y of the last pen-down frame |
| frame_done | output | 1 | One-cycle strobe after a frame completes |

## Verification
The evaluator is driven with directed frames that each isolate one decision:
- both guards well below the threshold;
- one guard above the threshold;
- a guard exactly equal to the threshold, which separates strict from non-strict comparison;
- frames that differ only in the settling slots, which shows whether slots 1 and 11 leak into the result.

Random frames with random idle gaps and random guard levels, mixed with in-range and out-of-range threshold writes, then exercise the event logic and the coordinate hold across many pen transitions. A frame abandoned midway and samples sent outside any frame show whether the slot counter restarts and whether the readback file stays tied to complete frames.

// File: rtl/tfe_pkg.sv
package tfe_pkg;
  localparam int FRAME_LEN = 12;
  localparam int IDX_W     = $clog2(FRAME_LEN + 4);

  typedef enum logic [2:0] {
    ROLE_SETTLE,
    ROLE_GUARD_EARLY,
    ROLE_X,
    ROLE_Y,
    ROLE_GUARD_LATE
  } slot_role_e;

  // slot numbering is 0 based here: slot 0 is the first sample of a frame
  function automatic slot_role_e role_of(input logic [IDX_W-1:0] s);
    if (s == IDX_W'(1))                            return ROLE_GUARD_EARLY;
    else if (s >= IDX_W'(2) && s <= IDX_W'(5))     return ROLE_X;
    else if (s >= IDX_W'(6) && s <= IDX_W'(9))     return ROLE_Y;
    else if (s == IDX_W'(FRAME_LEN - 1))           return ROLE_GUARD_LATE;
    else                                           return ROLE_SETTLE;
  endfunction
endpackage

// File: rtl/tfe_sequencer.sv
module tfe_sequencer
  import tfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             smp_valid,
  output logic             acc,
  output logic [IDX_W-1:0] slot,
  output logic             last
);
  logic             armed_q;
  logic [IDX_W-1:0] idx_q;

  assign acc  = smp_valid && (frame_start || armed_q);
  assign slot = frame_start ? '0 : idx_q;
  assign last = acc && (slot == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
    end else if (last) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
    end else if (acc) begin
      armed_q <= 1'b1;
      idx_q   <= slot + IDX_W'(1);
    end else if (frame_start) begin
      armed_q <= 1'b1;
      idx_q   <= '0;
    end
  end

  p_idx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(FRAME_LEN));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !smp_valid) |=> (armed_q && idx_q == '0));
endmodule

// File: rtl/tfe_rawfile.sv
module tfe_rawfile
  import tfe_pkg::*;
#(
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [IDX_W-1:0] slot,
  input  logic             last,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [IDX_W-1:0] raw_idx,
  output logic [SMP_W-1:0] raw_data
);
  logic [SMP_W-1:0] stage_q [FRAME_LEN];
  logic [SMP_W-1:0] vis_q   [FRAME_LEN];

  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
        vis_q[i]   <= '0;
      end else begin
        if (acc && slot == IDX_W'(i)) stage_q[i] <= smp_data;
        if (last) vis_q[i] <= (i == FRAME_LEN - 1) ? smp_data : stage_q[i];
      end
    end
  end

  always_comb begin
    raw_data = '0;
    for (int k = 0; k < FRAME_LEN; k++)
      if (raw_idx == IDX_W'(k)) raw_data = vis_q[k];
  end

  p_vis_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(vis_q[0]));
endmodule

// File: rtl/tfe_evaluator.sv
module tfe_evaluator
  import tfe_pkg::*;
#(
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [IDX_W-1:0] slot,
  input  logic             last,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [SMP_W-1:0] thr,
  output logic             pen_down,
  output logic             pen_down_evt,
  output logic             pen_up_evt,
  output logic [SMP_W-1:0] x_coord,
  output logic [SMP_W-1:0] y_coord,
  output logic             frame_done
);
  localparam int SUM_W = SMP_W + 2;

  logic [SUM_W-1:0] sum_x_q, sum_y_q;
  logic [SMP_W-1:0] guard_q;
  logic             pen_n;

  assign pen_n = (guard_q < thr) && (smp_data < thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_x_q <= '0;
      sum_y_q <= '0;
      guard_q <= '0;
    end else if (acc) begin
      unique case (role_of(slot))
        ROLE_SETTLE: if (slot == '0) begin
          sum_x_q <= '0;
          sum_y_q <= '0;
        end
        ROLE_GUARD_EARLY: guard_q <= smp_data;
        ROLE_X:           sum_x_q <= sum_x_q + SUM_W'(smp_data);
        ROLE_Y:           sum_y_q <= sum_y_q + SUM_W'(smp_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pen_down     <= 1'b0;
      pen_down_evt <= 1'b0;
      pen_up_evt   <= 1'b0;
      x_coord      <= '0;
      y_coord      <= '0;
      frame_done   <= 1'b0;
    end else begin
      frame_done   <= last;
      pen_down_evt <= last && pen_n && !pen_down;
      pen_up_evt   <= last && !pen_n && pen_down;
      if (last) begin
        pen_down <= pen_n;
        if (pen_n) begin
          x_coord <= sum_x_q[SUM_W-1:2];
          y_coord <= sum_y_q[SUM_W-1:2];
        end
      end
    end
  end

  p_evt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pen_down_evt, pen_up_evt}));
  p_evt_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_down_evt || pen_up_evt) |-> frame_done);
  p_down_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pen_down_evt |-> (pen_down && !$past(pen_down)));
  p_up_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pen_up_evt |-> (!pen_down && $past(pen_down)));
  p_coord_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !pen_down) |-> ($stable(x_coord) && $stable(y_coord)));
  p_pen_only_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(pen_down));
endmodule

// File: rtl/touch_frame_eval.sv
module touch_frame_eval
  import tfe_pkg::*;
#(
  parameter int SMP_W     = 10,
  parameter int THR_WR_W  = 16,
  parameter int THR_RESET = 750
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SMP_W-1:0]    smp_data,
  input  logic                thr_wr_en,
  input  logic [THR_WR_W-1:0] thr_wr_data,
  output logic [SMP_W-1:0]    thr_value,
  input  logic [IDX_W-1:0]    raw_idx,
  output logic [SMP_W-1:0]    raw_data,
  output logic                pen_down,
  output logic                pen_down_evt,
  output logic                pen_up_evt,
  output logic [SMP_W-1:0]    x_coord,
  output logic [SMP_W-1:0]    y_coord,
  output logic                frame_done
);
  localparam logic [THR_WR_W-1:0] THR_MAX = THR_WR_W'((1 << SMP_W) - 1);

  logic             acc, last;
  logic [IDX_W-1:0] slot;
  logic [SMP_W-1:0] thr_q;

  assign smp_ready = 1'b1;
  assign thr_value = thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                thr_q <= SMP_W'(THR_RESET);
    else if (thr_wr_en && thr_wr_data <= THR_MAX) thr_q <= thr_wr_data[SMP_W-1:0];
  end

  p_thr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr_en && thr_wr_data > THR_MAX) |=> $stable(thr_q));
  p_thr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr_en |=> $stable(thr_q));

  tfe_sequencer u_seq (
    .clk, .rst_n, .frame_start, .smp_valid,
    .acc, .slot, .last
  );

  tfe_rawfile #(.SMP_W(SMP_W)) u_raw (
    .clk, .rst_n, .acc, .slot, .last, .smp_data,
    .raw_idx, .raw_data
  );

  tfe_evaluator #(.SMP_W(SMP_W)) u_eval (
    .clk, .rst_n, .acc, .slot, .last, .smp_data,
    .thr(thr_q),
    .pen_down, .pen_down_evt, .pen_up_evt,
    .x_coord, .y_coord, .frame_done
  );
endmodule

// File: tb/sim_touch_frame_eval.sv
module sim_touch_frame_eval;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        frame_start = 0, smp_valid = 0, thr_wr_en = 0;
  logic [9:0]  smp_data = 0;
  logic [15:0] thr_wr_data = 0;
  logic [3:0]  raw_idx = 0;
  logic        smp_ready, pen_down, pen_down_evt, pen_up_evt, frame_done;
  logic [9:0]  thr_value, raw_data, x_coord, y_coord;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [9:0] fr [12];
  int m_thr = 750, m_x = 0, m_y = 0;
  bit m_pen = 0;
  logic [9:0] m_raw [12];

  always #(CLK_PERIOD/2) clk = ~clk;

  touch_frame_eval u0 (
    .clk, .rst_n, .frame_start, .smp_valid, .smp_ready, .smp_data,
    .thr_wr_en, .thr_wr_data, .thr_value, .raw_idx, .raw_data,
    .pen_down, .pen_down_evt, .pen_up_evt, .x_coord, .y_coord, .frame_done
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int avg4(input int first);
    return (int'(fr[first]) + int'(fr[first+1]) + int'(fr[first+2]) + int'(fr[first+3])) >> 2;
  endfunction

  task automatic check_raw(input string req);
    for (int i = 0; i < 12; i++) begin
      raw_idx = 4'(i); #1;
      check(req, raw_data, m_raw[i]);
    end
    raw_idx = 4'd12; #1; check(req, raw_data, 0);
    raw_idx = 4'd15; #1; check(req, raw_data, 0);
  endtask

  // Sends fr[] as one frame with up to gap idle cycles before each sample, then checks.
  task automatic run_frame(input int gap, input string req);
    bit pen_new, dn, up;
    @(negedge clk); frame_start = 1; smp_valid = 0;
    @(negedge clk); frame_start = 0;
    for (int i = 0; i < 12; i++) begin
      int g = (gap > 0) ? int'($urandom_range(gap, 0)) : 0;
      for (int k = 0; k < g; k++) begin
        smp_valid = 0; @(negedge clk);
      end
      smp_valid = 1; smp_data = fr[i];
      @(negedge clk);
    end
    smp_valid = 0;
    pen_new = (int'(fr[1]) < m_thr) && (int'(fr[11]) < m_thr);
    dn = pen_new && !m_pen;
    up = !pen_new && m_pen;
    m_pen = pen_new;
    if (pen_new) begin m_x = avg4(2); m_y = avg4(6); end
    for (int i = 0; i < 12; i++) m_raw[i] = fr[i];
    check({req, " R1 done"}, frame_done, 1);
    check({req, " R3 pen"}, pen_down, m_pen);
    check({req, " R6 down_evt"}, pen_down_evt, dn);
    check({req, " R6 up_evt"}, pen_up_evt, up);
    check({req, " R2/R5 x"}, x_coord, m_x);
    check({req, " R2/R5 y"}, y_coord, m_y);
    @(negedge clk);
    check({req, " R1 done one cycle"}, frame_done, 0);
    check({req, " R6 evt one cycle"}, pen_down_evt | pen_up_evt, 0);
  endtask

  task automatic write_thr(input int v);
    @(negedge clk); thr_wr_en = 1; thr_wr_data = 16'(v);
    @(negedge clk); thr_wr_en = 0;
    if (v <= 1023) m_thr = v;
    check((v > 1023) ? "R8 out-of-range ignored" : "R8 in-range write", thr_value, m_thr);
  endtask

  task automatic fill(input int g2, input int g12, input int xb, input int yb);
    fr[0] = 10'd1023; fr[1] = 10'(g2); fr[10] = 10'd1023; fr[11] = 10'(g12);
    for (int i = 0; i < 4; i++) begin
      fr[2+i] = 10'(xb + i);
      fr[6+i] = 10'(yb + 3*i);
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000 && !finished) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 12; i++) m_raw[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    check("R7 thr reset", thr_value, 750);
    check("R7 pen reset", pen_down, 0);
    check("R7 x reset", x_coord, 0);
    check("R1 ready", smp_ready, 1);
    check_raw("R9 raw reset");

    // R3 pen down with both guards below
    fill(300, 310, 100, 500); run_frame(0, "down");
    check_raw("R9 raw after frame");
    // R3 one guard above -> up; R5 coords hold
    fill(300, 900, 10, 20); run_frame(2, "late guard high");
    fill(900, 300, 10, 20); run_frame(0, "early guard high");
    // R3 guard equal to threshold counts as up
    fill(200, 300, 50, 60); run_frame(0, "down again");
    fill(750, 100, 70, 80); run_frame(0, "guard equal R3");
    fill(749, 749, 70, 80); run_frame(0, "guard just below R3");
    // R4 settling slots have no effect
    fill(100, 100, 400, 600); fr[0] = 0; fr[10] = 0; run_frame(1, "settle low R4");
    fill(100, 100, 400, 600); fr[0] = 1023; fr[10] = 1023; run_frame(1, "settle high R4");
    check("R4 x unchanged", x_coord, avg4(2));

    // R8 threshold writes
    write_thr(500);
    write_thr(2000);
    write_thr(1024);
    write_thr(1023);
    write_thr(0);
    fill(0, 0, 5, 5); run_frame(0, "thr zero R3");
    write_thr(750);

    // R1 samples outside a frame are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); smp_valid = 1; smp_data = 10'(i);
      #1 check("R1 no done outside frame", frame_done, 0);
    end
    @(negedge clk); smp_valid = 0;
    check("R1 no done outside frame", frame_done, 0);
    check_raw("R9 raw kept outside frame");

    // R10 mid-frame restart
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    for (int i = 0; i < 7; i++) begin
      smp_valid = 1; smp_data = 10'd999; @(negedge clk);
    end
    smp_valid = 0;
    check("R10 no done partial", frame_done, 0);
    check_raw("R9 raw kept partial R10");
    fill(120, 130, 333, 444); run_frame(0, "restart R10");
    check_raw("R9 raw after restart R10");

    // random frames
    for (int t = 0; t < 60; t++) begin
      if ($urandom_range(7, 0) == 0) write_thr(int'($urandom_range(1400, 0)));
      for (int i = 0; i < 12; i++) fr[i] = 10'($urandom_range(1023, 0));
      if ($urandom_range(1, 0) == 1) begin
        fr[1] = 10'($urandom_range(m_thr > 0 ? m_thr : 0, 0));
        fr[11] = 10'($urandom_range(m_thr > 0 ? m_thr : 0, 0));
      end
      run_frame(3, "random");
    end
    check_raw("R9 raw final");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule